// File: doc/BRIEF.md
# Two-Wire Bus Activity Watchdog

This block watches the data and clock lines of a two-wire serial bus and uses them as a watchdog. The host keeps the watchdog quiet by placing a START condition on the bus and then a STOP condition. It needs no separate kick pin. Both lines are first brought into the local clock domain. After that the block finds the START and STOP conditions and runs a timeout counter. When the counter reaches the chosen limit, the block raises a one-cycle expiry pulse toward the reset sequencer.

A 2-bit input, held in a control register elsewhere, chooses the timeout: long, medium, short, or disabled. The three limits are parameters given in clock cycles. Their defaults are scaled down versions of the 1.4 s, 600 ms and 200 ms periods. A pulse for each detected bus condition is also brought out for use by neighbouring logic.

Top module: `bus_wdog`

## Requirements
- R1: While `rst_n` is low, `expirePulse`, `startSeen` and `stopSeen` are low and the count is held at zero. After release, with no kick, the first pulse is seen right after the Nth rising clock edge.
- R2: When SDA goes from high to low while SCL is high, `startSeen` is high for exactly one cycle. It is seen after the second rising edge that follows the pin change. When SDA falls while SCL is low, this is not a START.
- R3: When SDA goes from low to high while SCL is high, `stopSeen` is high for exactly one cycle, with the same two-edge latency. When SDA rises while SCL is low, this is not a STOP.
- R4: `timeoutSel` chooses N as follows: 2'b10 is SHORT_CYC (200), 2'b01 is MID_CYC (600), and 2'b00 is LONG_CYC (1400). `expirePulse` is high for exactly one cycle.
- R5: With no kick, the expiry pulse repeats every N cycles.
- R6: A STOP that follows a START is a kick. It clears the count on the edge where `stopSeen` is sampled, and the next pulse comes N edges later.
- R7: A START with no STOP after it, or a STOP with no START before it, does not restart the count.
- R8: A repeated START, with no STOP in between, keeps the kick armed. The STOP that follows is still a kick.
- R9: If a kick falls on the edge where the count would expire, the kick wins. No pulse is issued, and the count restarts from zero.
- R10: `timeoutSel` = 2'b11 turns the watchdog off. No pulse is issued and the count is held at zero. When another setting is chosen, counting starts again from zero.
- R11: If a shorter setting is chosen while the count is already at or beyond the new limit, the pulse is issued on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdaPin | input | 1 | Bus data line, asynchronous |
| sclPin | input | 1 | Bus clock line, asynchronous |
| timeoutSel | input | 2 | Timeout setting (00 long, 01 medium, 10 short, 11 off) |
| expirePulse | output | 1 | One-cycle timeout pulse to the reset sequencer |
| startSeen | output | 1 | One-cycle pulse on each detected START |
| stopSeen | output | 1 | One-cycle pulse on each detected STOP |

## Verification
Two things can fall on the same clock edge: a kick and the count reaching its limit. To make them meet, the bench arms a kick with a START. It then raises SDA three edges before the limit, so that the synchroniser delay makes the STOP arrive on exactly the limit edge. The bench then checks that no pulse appears on that edge, and that the next pulse comes a full period later. That shows the kick won and also restarted the count.

// File: rtl/bus_wdog_pkg.sv
package bus_wdog_pkg;
  typedef struct packed {
    logic start;
    logic stop;
  } busEvt_t;

  typedef struct packed {
    logic clear;
    logic fire;
    logic kick;
  } wdStrobe_t;

  localparam logic [1:0] SEL_LONG  = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_OFF   = 2'b11;
endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RESET_VAL;
        else if (s == 0) chain[s] <= din;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/wd_datapath.sv
module wd_datapath
  import bus_wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LONG_CYC  = 1400,
  parameter int MID_CYC   = 600,
  parameter int SHORT_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sdaPin,
  input  logic       sclPin,
  input  logic [1:0] timeoutSel,
  input  wdStrobe_t  stb,
  output busEvt_t    evt,
  output logic       atLimit,
  output logic       expirePulse
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] MID_LAST   = CW'(MID_CYC - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

  logic sdaSync, sclSync, sdaPrev, sclPrev;
  logic [CW-1:0] count, lastVal;

  wd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sdaSyncI (
    .clk(clk), .rst_n(rst_n), .din(sdaPin), .dout(sdaSync));
  wd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sclSyncI (
    .clk(clk), .rst_n(rst_n), .din(sclPin), .dout(sclSync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdaPrev <= 1'b1;
      sclPrev <= 1'b1;
    end else begin
      sdaPrev <= sdaSync;
      sclPrev <= sclSync;
    end
  end

  assign evt.start = sdaPrev & ~sdaSync & sclPrev & sclSync;
  assign evt.stop  = ~sdaPrev & sdaSync & sclPrev & sclSync;

  always_comb begin
    unique case (timeoutSel)
      SEL_LONG:  lastVal = LONG_LAST;
      SEL_MID:   lastVal = MID_LAST;
      SEL_SHORT: lastVal = SHORT_LAST;
      default:   lastVal = SHORT_LAST;
    endcase
  end

  assign atLimit = (count >= lastVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      expirePulse <= 1'b0;
    end else begin
      count       <= stb.clear ? '0 : count + 1'b1;
      expirePulse <= stb.fire;
    end
  end
endmodule

// File: rtl/wd_control.sv
module wd_control
  import bus_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  busEvt_t    evt,
  input  logic       atLimit,
  input  logic [1:0] timeoutSel,
  output wdStrobe_t  stb
);
  logic armed, isOff;

  assign isOff = (timeoutSel == SEL_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (evt.start) armed <= 1'b1;
    else if (evt.stop) armed <= 1'b0;
  end

  always_comb begin
    stb.kick  = evt.stop & armed;
    stb.fire  = atLimit & ~stb.kick & ~isOff;
    stb.clear = stb.kick | isOff | atLimit;
  end
endmodule

// File: rtl/bus_wdog.sv
module bus_wdog
  import bus_wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LONG_CYC  = 1400,
  parameter int MID_CYC   = 600,
  parameter int SHORT_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sdaPin,
  input  logic       sclPin,
  input  logic [1:0] timeoutSel,
  output logic       expirePulse,
  output logic       startSeen,
  output logic       stopSeen
);
  busEvt_t   evt;
  wdStrobe_t stb;
  logic      atLimit;

  wd_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .LONG_CYC(LONG_CYC),
    .MID_CYC(MID_CYC), .SHORT_CYC(SHORT_CYC)
  ) dpI (
    .clk(clk), .rst_n(rst_n), .sdaPin(sdaPin), .sclPin(sclPin),
    .timeoutSel(timeoutSel), .stb(stb), .evt(evt),
    .atLimit(atLimit), .expirePulse(expirePulse));

  wd_control ctlI (
    .clk(clk), .rst_n(rst_n), .evt(evt), .atLimit(atLimit),
    .timeoutSel(timeoutSel), .stb(stb));

  assign startSeen = evt.start;
  assign stopSeen  = evt.stop;
endmodule

// File: rtl/bus_wdog_checker.sv
module bus_wdog_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] timeoutSel,
  input logic       expirePulse,
  input logic       startSeen,
  input logic       stopSeen,
  input logic       kickNow
);
  // R4: the expiry output never holds for two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expirePulse |=> !expirePulse);

  // R10: off setting in the previous cycle means no pulse now
  a_r10_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(timeoutSel) == 2'b11) |-> !expirePulse);

  // R2 / R3: START and STOP never detected together
  a_r2_exclusive_events: assert property (@(posedge clk) disable iff (!rst_n)
    !(startSeen && stopSeen));

  // R6: a kick only comes with a detected STOP
  a_r6_kick_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    kickNow |-> stopSeen);

  // R9: a kick suppresses the pulse of the same edge
  a_r9_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
    kickNow |=> !expirePulse);

  // R2: detection pulses last a single cycle
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    startSeen |=> !startSeen);
endmodule

bind bus_wdog bus_wdog_checker chkI (
  .clk(clk), .rst_n(rst_n), .timeoutSel(timeoutSel),
  .expirePulse(expirePulse), .startSeen(startSeen),
  .stopSeen(stopSeen), .kickNow(stb.kick));

// File: tb/bus_wdog_test.sv
module bus_wdog_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdaPin = 1'b1;
  logic sclPin = 1'b1;
  logic [1:0] timeoutSel = 2'b10;
  logic expirePulse, startSeen, stopSeen;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;
  logic gotSt, gotSp;
  int pulses;

  always #4 clk = ~clk;

  bus_wdog uut (
    .clk(clk), .rst_n(rst_n), .sdaPin(sdaPin), .sclPin(sclPin),
    .timeoutSel(timeoutSel), .expirePulse(expirePulse),
    .startSeen(startSeen), .stopSeen(stopSeen));

  // {expected pulse, select, edge to sample}
  localparam int VEC_N = 8;
  localparam logic [18:0] VECS [VEC_N] = '{
    {1'b0, 2'b10, 16'd199},  {1'b1, 2'b10, 16'd200},
    {1'b0, 2'b01, 16'd599},  {1'b1, 2'b01, 16'd600},
    {1'b0, 2'b00, 16'd1399}, {1'b1, 2'b00, 16'd1400},
    {1'b0, 2'b11, 16'd200},  {1'b0, 2'b11, 16'd1400}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: actual %b expected %b", req, edgeNo, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      edgeNo++;
    end
  endtask

  task automatic waitUntil(input int n);
    while (edgeNo < n) tick(1);
  endtask

  task automatic doReset(input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0;
    sdaPin = 1'b1;
    sclPin = 1'b1;
    timeoutSel = sel;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset expire", expirePulse, 1'b0);
    chk("R1 reset start", startSeen, 1'b0);
    chk("R1 reset stop", stopSeen, 1'b0);
    rst_n = 1'b1;
    edgeNo = 0;
  endtask

  // drive pins, return detection flags after two edges, settle on a third
  task automatic busSet(input logic sda, input logic scl, output logic st, output logic sp);
    sdaPin = sda;
    sclPin = scl;
    tick(2);
    st = startSeen;
    sp = stopSeen;
    tick(1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // table walk: R1 R4 R10
    for (int i = 0; i < VEC_N; i++) begin
      doReset(VECS[i][17:16]);
      waitUntil(int'(VECS[i][15:0]));
      chk("R4 table timeout", expirePulse, VECS[i][18]);
    end

    // R5: periodic expiry
    doReset(2'b10);
    waitUntil(200); chk("R5 first", expirePulse, 1'b1);
    waitUntil(201); chk("R4 one cycle", expirePulse, 1'b0);
    waitUntil(399); chk("R5 before second", expirePulse, 1'b0);
    waitUntil(400); chk("R5 second", expirePulse, 1'b1);

    // R2 R3 R6: start then stop kicks at edge 56
    doReset(2'b10);
    waitUntil(50);
    busSet(1'b0, 1'b1, gotSt, gotSp);
    chk("R2 start seen", gotSt, 1'b1);
    chk("R2 start single", startSeen, 1'b0);
    busSet(1'b1, 1'b1, gotSt, gotSp);
    chk("R3 stop seen", gotSp, 1'b1);
    chk("R3 no start on stop", gotSt, 1'b0);
    waitUntil(200); chk("R6 kick delays", expirePulse, 1'b0);
    waitUntil(255); chk("R6 before new limit", expirePulse, 1'b0);
    waitUntil(256); chk("R6 new limit", expirePulse, 1'b1);

    // R7: start alone
    doReset(2'b10);
    waitUntil(50);
    busSet(1'b0, 1'b1, gotSt, gotSp);
    waitUntil(200); chk("R7 start alone", expirePulse, 1'b1);

    // R7 R2 R3: stop alone, and edges while SCL low
    doReset(2'b10);
    waitUntil(40);
    busSet(1'b1, 1'b0, gotSt, gotSp);
    busSet(1'b0, 1'b0, gotSt, gotSp);
    chk("R2 fall with scl low", gotSt, 1'b0);
    busSet(1'b1, 1'b0, gotSt, gotSp);
    chk("R3 rise with scl low", gotSp, 1'b0);
    busSet(1'b0, 1'b0, gotSt, gotSp);
    busSet(1'b0, 1'b1, gotSt, gotSp);
    busSet(1'b1, 1'b1, gotSt, gotSp);
    chk("R3 stop alone seen", gotSp, 1'b1);
    waitUntil(200); chk("R7 stop alone", expirePulse, 1'b1);

    // R8: repeated start then stop
    doReset(2'b10);
    waitUntil(20);
    busSet(1'b0, 1'b1, gotSt, gotSp);
    busSet(1'b0, 1'b0, gotSt, gotSp);
    busSet(1'b1, 1'b0, gotSt, gotSp);
    busSet(1'b1, 1'b1, gotSt, gotSp);
    busSet(1'b0, 1'b1, gotSt, gotSp);
    chk("R8 repeated start seen", gotSt, 1'b1);
    busSet(1'b1, 1'b1, gotSt, gotSp);
    waitUntil(200); chk("R8 kick after restart", expirePulse, 1'b0);
    waitUntil(238); chk("R8 new limit", expirePulse, 1'b1);

    // R9: kick lands on the expiry edge
    doReset(2'b10);
    waitUntil(10);
    busSet(1'b0, 1'b1, gotSt, gotSp);
    waitUntil(197);
    busSet(1'b1, 1'b1, gotSt, gotSp);
    chk("R9 collision no pulse", expirePulse, 1'b0);
    waitUntil(399); chk("R9 before restart limit", expirePulse, 1'b0);
    waitUntil(400); chk("R9 restart limit", expirePulse, 1'b1);

    // R10: off holds zero, then on counts from zero
    doReset(2'b11);
    pulses = 0;
    for (int k = 0; k < 3000; k++) begin
      tick(1);
      if (expirePulse) pulses++;
    end
    chk("R10 off no pulses", pulses != 0, 1'b0);
    timeoutSel = 2'b10;
    waitUntil(3199); chk("R10 resume before", expirePulse, 1'b0);
    waitUntil(3200); chk("R10 resume from zero", expirePulse, 1'b1);

    // R11: lowering the limit below the count
    doReset(2'b00);
    waitUntil(500);
    timeoutSel = 2'b10;
    waitUntil(501); chk("R11 immediate pulse", expirePulse, 1'b1);
    waitUntil(700); chk("R11 before next", expirePulse, 1'b0);
    waitUntil(701); chk("R11 next period", expirePulse, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule